// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches 32 external input pins and turns activity on them into interrupt requests for a processor's interrupt controller. The pins are organised as four groups of eight. Each pin carries a three-bit trigger selection, a mask bit and a pending bit. Every pin input is resynchronised before detection. A detected event latches the pin's pending bit whatever the pin's mask says.

Pins 0 to 15 each have a dedicated request line, raised while the pin is pending and unmasked. Pins 16 to 31 share one request line. The handler for that shared line reads the pending and mask registers of the upper two groups to find out which pin fired, and then clears the pending bits it has served by writing ones to them.

Registers are accessed by word index `reg_addr = {kind, group}`. Here `kind` is the upper two bits (0 trigger configuration, 1 mask, 2 pending, 3 unused) and `group` is the lower two bits. Reads are combinational. A write with `reg_we` high takes effect on the next rising clock edge.

Top module: `ext_pin_irq`

## Requirements
- R1: After reset every mask register reads 0xFF, every pending and configuration register reads 0, and all request outputs are low.
- R2: Pin k's trigger code sits at bits [4j+2:4j] of configuration register k/8, where j = k mod 8. Bit 4j+3 and bits above the nibbles always read 0. Index kind 3 reads 0 and ignores writes.
- R3: A change on a pin input is first reflected in its pending bit on the third rising clock edge after the change, because of two synchronising flops.
- R4: Trigger codes are 0 level low, 1 level high, 2 falling edge, 3 rising edge and 4 either edge.
- R5: Trigger codes 5, 6 and 7 never set a pending bit, whatever the pin does.
- R6: Writing a 1 to a pending bit (register bits [7:0] of kind 2) clears it. A 0 leaves it unchanged, and no pending write can set a bit.
- R7: For the level codes the pending bit is set again on every cycle the level holds. A clear therefore only sticks once the level has gone away.
- R8: A pending bit latches even while its pin is masked (mask bit 1), and it stays set until cleared.
- R9: For pins 0 to 15, `irq_ded[k]` is high exactly when pending bit k is 1 and mask bit k is 0. Mask writes load register bits [7:0] of kind 1.
- R10: `irq_shared` is high exactly when any of pins 16 to 31 is both pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous external pin inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word index {kind[1:0], group[1:0]} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_ded | output | 16 | Dedicated request lines for pins 0 to 15 |
| irq_shared | output | 1 | Shared request line for pins 16 to 31 |

## Verification
The assertions check the pending register every cycle. A bit can only rise if a detector event was present on the cycle before, and an event always leaves its bit set. A bit can only fall where a one was written to it while no event was active. The mask holds its value unless it is written. Only the bench can show the rest: that each trigger code picks the right pin behaviour, that detection has a three-edge latency, that a held level defeats a clear, and that a masked event appears on the output once the pin is unmasked. It shows these by comparing both outputs every cycle against a reference model driven by random pin toggles and register writes, and by directed sequences with fixed expected values.

// File: rtl/ext_pin_irq.sv
module ext_pin_irq #(
  parameter int NGRP = 4,
  parameter int NDED = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NGRP*8-1:0]       pin_i,
  input  logic                    reg_we,
  input  logic [$clog2(NGRP)+1:0] reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic [NDED-1:0]         irq_ded,
  output logic                    irq_shared
);

  localparam int NPIN = NGRP * 8;
  localparam int GW   = $clog2(NGRP);
  localparam logic [1:0] K_CFG  = 2'd0;
  localparam logic [1:0] K_MASK = 2'd1;
  localparam logic [1:0] K_PEND = 2'd2;

  logic [1:0]      kind;
  logic [GW-1:0]   grp;
  logic [NPIN-1:0] sy1, sy2, sy3;
  logic [NPIN-1:0] mask_q, pend_q, evt, clr;
  logic [2:0]      typ_q [NPIN];
  logic            past_ok;

  assign kind = reg_addr[GW+1:GW];
  assign grp  = reg_addr[GW-1:0];

  function automatic logic detect(input logic [2:0] t, input logic now, input logic was);
    case (t)
      3'd0:    return ~now;
      3'd1:    return now;
      3'd2:    return ~now & was;
      3'd3:    return now & ~was;
      3'd4:    return now ^ was;
      default: return 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= pin_i;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    assign evt[k] = detect(typ_q[k], sy2[k], sy3[k]);
    assign clr[k] = reg_we && kind == K_PEND && grp == GW'(k / 8) && reg_wdata[k % 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NPIN; k++) typ_q[k] <= 3'd0;
      mask_q <= '1;
    end else if (reg_we) begin
      for (int g = 0; g < NGRP; g++) begin
        if (grp == GW'(g)) begin
          if (kind == K_CFG)
            for (int j = 0; j < 8; j++) typ_q[g*8+j] <= reg_wdata[4*j +: 3];
          if (kind == K_MASK)
            mask_q[g*8 +: 8] <= reg_wdata[7:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | evt;
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp == GW'(g)) begin
        case (kind)
          K_CFG:   for (int j = 0; j < 8; j++) reg_rdata[4*j +: 3] = typ_q[g*8+j];
          K_MASK:  reg_rdata[7:0] = mask_q[g*8 +: 8];
          K_PEND:  reg_rdata[7:0] = pend_q[g*8 +: 8];
          default: reg_rdata = '0;
        endcase
      end
    end
  end

  assign irq_ded    = pend_q[NDED-1:0] & ~mask_q[NDED-1:0];
  assign irq_shared = |(pend_q[NPIN-1:NDED] & ~mask_q[NPIN-1:NDED]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n) past_ok |-> ((pend_q & $past(evt)) == $past(evt)));  // R8
  AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) past_ok |-> ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0));  // R3
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) past_ok |-> ((pend_q & $past(clr & ~evt)) == '0));  // R6
  AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n) past_ok |-> (($past(pend_q) & ~pend_q & ~$past(clr)) == '0));  // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (past_ok && !$past(reg_we && kind == K_MASK)) |-> $stable(mask_q));  // R9

endmodule

// File: tb/ext_pin_irq_tb.sv
`timescale 1ns/1ps
module ext_pin_irq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_i = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_ded;
  logic        irq_shared;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  ext_pin_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ded(irq_ded), .irq_shared(irq_shared)
  );

  logic [2:0]  m_typ [32];
  logic [31:0] m_mask, m_pend, m_s1, m_s2, m_s3, m_ev, m_cl;

  function automatic logic mdet(input logic [2:0] t, input logic now, input logic was);
    if (t == 3'd0) return !now;
    if (t == 3'd1) return now;
    if (t == 3'd2) return was && !now;
    if (t == 3'd3) return now && !was;
    if (t == 3'd4) return now != was;
    return 1'b0;
  endfunction

  function automatic logic [31:0] mread(input logic [3:0] a);
    logic [31:0] r;
    r = '0;
    case (a[3:2])
      2'd0: for (int j = 0; j < 8; j++) r[4*j +: 3] = m_typ[a[1:0]*8+j];
      2'd1: r[7:0] = m_mask[a[1:0]*8 +: 8];
      2'd2: r[7:0] = m_pend[a[1:0]*8 +: 8];
      default: r = '0;
    endcase
    return r;
  endfunction

  initial begin
    for (int k = 0; k < 32; k++) m_typ[k] = 3'd0;
    m_mask = '1; m_pend = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 32; k++) m_typ[k] = 3'd0;
      m_mask = '1; m_pend = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
    end else begin
      for (int k = 0; k < 32; k++) begin
        m_ev[k] = mdet(m_typ[k], m_s2[k], m_s3[k]);
        m_cl[k] = reg_we && reg_addr[3:2] == 2'd2 && int'(reg_addr[1:0]) == k / 8 && reg_wdata[k % 8];
      end
      m_pend = (m_pend & ~m_cl) | m_ev;
      if (reg_we && reg_addr[3:2] == 2'd0)
        for (int j = 0; j < 8; j++) m_typ[reg_addr[1:0]*8+j] = reg_wdata[4*j +: 3];
      if (reg_we && reg_addr[3:2] == 2'd1)
        m_mask[reg_addr[1:0]*8 +: 8] = reg_wdata[7:0];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_i;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk({16'h0, irq_ded}, {16'h0, m_pend[15:0] & ~m_mask[15:0]}, "R9 irq_ded vs model");
      chk({31'h0, irq_shared}, {31'h0, |(m_pend[31:16] & ~m_mask[31:16])}, "R10 irq_shared vs model");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [3:0] ra;
    void'($urandom(32'd20240611));
    tick(3);
    // R1 reset state, still in reset
    for (int g = 0; g < 4; g++) begin
      rd(4'(4 + g), 32'h0000_00FF, "R1 mask reset");
      rd(4'(8 + g), 32'h0, "R1 pending reset");
      rd(4'(g), 32'h0, "R1 config reset");
    end
    chk({15'h0, irq_ded, irq_shared}, 32'h0, "R1 outputs reset");
    rst_n = 1'b1;

    for (int g = 0; g < 4; g++) wr(4'(g), 32'h5555_5555);
    tick(3);
    for (int g = 0; g < 4; g++) wr(4'(8 + g), 32'h0000_00FF);
    for (int g = 0; g < 4; g++) rd(4'(8 + g), 32'h0, "R6 clear all");

    // R5 disabled codes
    pin_i = '1; tick(4); pin_i = '0; tick(4);
    for (int g = 0; g < 4; g++) rd(4'(8 + g), 32'h0, "R5 disabled code");

    // R3 / R4 rising edge on pin 3
    wr(4'd0, 32'h5555_3555);
    wr(4'd4, 32'h0000_00F7);
    pin_i[3] = 1'b1;
    tick(1); chk({31'h0, irq_ded[3]}, 32'h0, "R3 edge 1");
    tick(1); chk({31'h0, irq_ded[3]}, 32'h0, "R3 edge 2");
    tick(1); chk({31'h0, irq_ded[3]}, 32'h1, "R3 R4 edge 3 rising");

    // R6 write-one-to-clear
    wr(4'd8, 32'h0);
    rd(4'd8, 32'h08, "R6 zero write keeps");
    wr(4'd8, 32'h08);
    rd(4'd8, 32'h0, "R6 one write clears");
    chk({31'h0, irq_ded[3]}, 32'h0, "R6 output drops");

    // R7 / R10 level high on pin 20
    wr(4'd2, 32'h5551_5555);
    wr(4'd6, 32'h0000_00EF);
    pin_i[20] = 1'b1;
    tick(3);
    chk({31'h0, irq_shared}, 32'h1, "R10 shared raised");
    wr(4'd10, 32'h10);
    rd(4'd10, 32'h10, "R7 level defeats clear");
    pin_i[20] = 1'b0;
    tick(3);
    rd(4'd10, 32'h10, "R7 still latched");
    wr(4'd10, 32'h10);
    rd(4'd10, 32'h0, "R7 clear sticks");
    chk({31'h0, irq_shared}, 32'h0, "R10 shared dropped");

    // R8 masked falling edge on pin 9
    wr(4'd1, 32'h5555_5525);
    pin_i[9] = 1'b1; tick(4);
    pin_i[9] = 1'b0; tick(4);
    rd(4'd9, 32'h02, "R8 latched while masked");
    chk({31'h0, irq_ded[9]}, 32'h0, "R8 output blocked");
    wr(4'd5, 32'h0000_00FD);
    chk({31'h0, irq_ded[9]}, 32'h1, "R9 unmask reveals");

    // R2 field layout and unused kind
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, 32'h7777_7777, "R2 gap bits read zero");
    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd15, 32'h0, "R2 unused kind");

    // R4 level low on pin 25
    wr(4'd3, 32'h5555_5505);
    wr(4'd7, 32'h0000_00FD);
    tick(1);
    chk({31'h0, irq_shared}, 32'h1, "R4 level low");
    pin_i[25] = 1'b1; tick(3);
    wr(4'd11, 32'h02);
    rd(4'd11, 32'h0, "R4 level low released");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      ra = 4'($urandom % 16);
      rd(ra, mread(ra), ra[3:2] == 2'd0 ? "R2 random config" :
                        ra[3:2] == 2'd1 ? "R9 random mask" :
                        ra[3:2] == 2'd2 ? "R4 random pending" : "R2 random unused");
      pin_i = pin_i ^ ($urandom & $urandom & $urandom);
      if ($urandom % 4 == 0) begin
        reg_we = 1'b1; reg_addr = 4'($urandom % 16); reg_wdata = $urandom;
      end else begin
        reg_we = 1'b0;
      end
      @(negedge clk);
    end
    reg_we = 1'b0;
    tick(2);
    summary();
  end

endmodule